// File: doc/BRIEF.md
# Programmable Poll Interval Timer

This block produces a one-cycle poll request at a fixed, software-chosen spacing, so that a network controller knows when to look at its descriptor rings again. The spacing comes from a 16-bit field that holds the two's complement of the wanted period. The sign is implied and is always one. Bit 15 is the most significant bit of the number, and the low four bits are kept in the field but do not affect the period. Each count is one clock.

The field sits in the low half of a 32-bit register port. Reads are always allowed. A write lands only while the controller reports that it is stopped or suspended, and any other write is dropped. An initialization pulse restores the default value 0000h, which gives the longest period of 65,536 clocks. The counter picks up a newly written value only when the current interval ends. An enable input freezes the count while it is low.

Top module: `poll_interval_timer`

## Requirements
- R1: After reset the field reads 0000h, and the first poll pulse appears after exactly 65,536 enabled clock cycles.
- R2: The spacing between poll pulses, in clocks, is 65536 minus the field with its bits 3..0 forced to zero. For example, FFF0h gives 16. Each pulse lasts exactly one cycle.
- R3: Bits 3..0 of the field do not change the period, but they are stored and read back as written.
- R4: A write with stopped or suspended high loads reg_wdata[15:0] into the field.
- R5: A write with both stopped and suspended low is discarded. The field and the pulse spacing stay unchanged.
- R6: reg_rdata[15:0] always returns the field and reg_rdata[31:16] always returns zero.
- R7: A pulse on init_load sets the field to 0000h. It wins over a write in the same cycle.
- R8: A new field value takes effect at the next reload. The interval already in progress finishes with the old value.
- R9: While tmr_en is low the count holds and no pulse is issued. Counting resumes from the held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| stopped | input | 1 | Controller stopped status |
| suspended | input | 1 | Controller suspended status |
| init_load | input | 1 | Pulse that loads the default field value |
| tmr_en | input | 1 | Counting enable |
| poll_pulse | output | 1 | One-cycle poll request |

## Verification
Some properties can be checked on every cycle: a write outside the stopped or suspended state leaves the field unchanged, init_load clears it, a disabled counter holds and stays silent, the pulse never lasts more than one cycle, and the counter's implied top bit stays set. Other behaviour needs the bench's scenarios to show it. That includes the arithmetic link between the field and the measured pulse spacing, the point at which a rewritten value takes effect, and the fact that the ignored low bits leave the spacing unchanged. The bench covers these with a sweep of sixteen periods.

// File: rtl/poll_interval_timer.sv
module poll_interval_timer #(
  parameter int FIELD_W = 16,
  parameter int IGN_W   = 4,
  parameter int REG_W   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             stopped,
  input  logic             suspended,
  input  logic             init_load,
  input  logic             tmr_en,
  output logic             poll_pulse
);
  localparam int CNT_W = FIELD_W + 1;

  logic [FIELD_W-1:0] intv_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   reload;
  logic               wr_ok;
  logic               wrap;

  assign wr_ok     = reg_wr && (stopped || suspended);
  assign reload    = {1'b1, intv_q[FIELD_W-1:IGN_W], {IGN_W{1'b0}}};
  assign wrap      = tmr_en && (cnt_q == {CNT_W{1'b1}});
  assign reg_rdata = {{(REG_W-FIELD_W){1'b0}}, intv_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         intv_q <= '0;
    else if (init_load) intv_q <= '0;
    else if (wr_ok)     intv_q <= reg_wdata[FIELD_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= {1'b1, {FIELD_W{1'b0}}};
      poll_pulse <= 1'b0;
    end else begin
      poll_pulse <= wrap;
      if (wrap)        cnt_q <= reload;
      else if (tmr_en) cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_WRITE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !stopped && !suspended && !init_load) |=> $stable(intv_q)); // R5
  AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    init_load |=> (intv_q == '0)); // R7
  AST_HOLD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_en |=> ($stable(cnt_q) && !poll_pulse)); // R9
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    poll_pulse |=> !poll_pulse); // R2
  AST_IMPLIED_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q[CNT_W-1]); // R2
endmodule

// File: tb/poll_interval_timer_bench.sv
module poll_interval_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        stopped = 1'b1;
  logic        suspended = 1'b0;
  logic        init_load = 1'b0;
  logic        tmr_en = 1'b1;
  logic        poll_pulse;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_pulse = 0;
  int gap = 0;
  int npulse = 0;
  int wide = 0;
  logic prev_pulse = 1'b0;

  always #5 clk = ~clk;

  poll_interval_timer u_poll_interval_timer (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .stopped(stopped), .suspended(suspended),
    .init_load(init_load), .tmr_en(tmr_en), .poll_pulse(poll_pulse));

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (poll_pulse && prev_pulse) wide = wide + 1;
    prev_pulse = poll_pulse;
    if (poll_pulse) begin
      gap = cyc - last_pulse;
      last_pulse = cyc;
      npulse = npulse + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic next_gap(output int g);
    int s = npulse;
    wait (npulse != s);
    g = gap;
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1;
    reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    reg_wdata = '0;
  endtask

  initial begin
    #1_900_000;
    errors++;
    $display("FAIL watchdog actual %0d expected 0", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int g;
    int g1;
    repeat (3) @(negedge clk);
    check("R1 reset field", int'(reg_rdata), 0);
    rst_n = 1'b1;
    last_pulse = cyc;
    next_gap(g);
    check("R1 first period", g, 65536);
    wr(32'h0000_FFF0);
    check("R4 readback", int'(reg_rdata), 32'hFFF0);
    next_gap(g);
    check("R8 old interval finishes", g, 65536);
    next_gap(g);
    check("R2 period FFF0", g, 16);
    check("R2 pulse width", wide, 0);

    for (int k = 1; k <= 16; k++) begin
      logic [15:0] v;
      v = 16'((65536 - 16 * k) | (k & 15));
      stopped   = k[0];
      suspended = ~k[0];
      wr({16'h0, v});
      check("R4 written value", int'(reg_rdata), int'(v));
      check("R6 upper half zero", int'(reg_rdata[31:16]), 0);
      next_gap(g1);
      next_gap(g);
      check("R3 low bits ignored period", g, 16 * k);
    end

    stopped = 1'b0;
    suspended = 1'b0;
    wr(32'h0000_FFF0);
    check("R5 write discarded", int'(reg_rdata), 32'hFF00);
    next_gap(g1);
    next_gap(g);
    check("R5 period unchanged", g, 256);

    stopped = 1'b1;
    wr(32'h0000_FFF0);
    next_gap(g1);
    next_gap(g);
    @(negedge clk);
    tmr_en = 1'b0;
    repeat (10) @(negedge clk);
    check("R9 no pulse while held", int'(poll_pulse), 0);
    tmr_en = 1'b1;
    next_gap(g);
    check("R9 held interval", g, 26);
    next_gap(g);
    check("R9 resumes normal", g, 16);

    @(negedge clk);
    reg_wr = 1'b1;
    reg_wdata = 32'h0000_ABCD;
    init_load = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    init_load = 1'b0;
    check("R7 init beats write", int'(reg_rdata), 0);
    wr(32'h0000_1235);
    check("R3 low bits stored", int'(reg_rdata), 32'h1235);
    @(negedge clk);
    init_load = 1'b1;
    @(negedge clk);
    init_load = 1'b0;
    check("R7 init clears", int'(reg_rdata), 0);
    check("R2 pulse never wide", wide, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule